// File: doc/BRIEF.md
# Multithreaded Core Partition Controller

This block owns the partitioning of an eight-thread processor core into one, two or four subcores. Each subcore is a group of consecutive threads. A small control register holds three bits: a guard bit that blocks automatic merging, and two split request bits. Only thread 0 can write this register. The controller reports the current partition on two read-only status pins and gives every thread its subcore number.

A split is started by writing the guard bit together with exactly one request bit while the core is whole. The split takes effect on the next clock edge, and the request bits then clear. Merging back is never commanded. It happens without software action when the guard bit is clear and every thread except thread 0 reports that it is napping. The two split modes can only reach each other by passing through the whole-core mode. Software polls the status pins to learn when a change has finished.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies.

Top module: `core_partition_ctrl`

## Requirements
- R1: After reset the core is whole: both status pins read 0, the control readback is 3'b000, and every thread's subcore number is 0.
- R2: The subcore number of thread t is 0 when the core is whole, t/4 in 2-way mode, and t/2 in 4-way mode, with 2 bits per thread and thread t at bits [2t+1:2t] of `subcore_idx`.
- R3: The control word has the guard bit at bit 0, the split-to-2 request at bit 1 and the split-to-4 request at bit 2. When the core is whole and the register holds the guard bit with exactly one request bit, the matching split is applied on the next clock edge.
- R4: `mode_two` reads 1 only in 2-way mode and `mode_four` reads 1 only in 4-way mode. Both read 0 when the core is whole, and they are never 1 together.
- R5: When the guard bit is clear and nap[7:1] are all 1, a split core returns to whole on the next clock edge. nap[0] has no influence on this.
- R6: While the guard bit is set, a split core never returns to whole, whatever the nap inputs do.
- R7: A split request seen while the core is already split is ignored: the mode does not change, so 2-way and 4-way never follow each other directly.
- R8: A request with both request bits set is ignored, and the core stays whole.
- R9: A request without the guard bit is ignored, and the core stays whole.
- R10: Writes whose `wr_tid` is not 0 leave the control register unchanged.
- R11: Any nonzero request field is cleared on the clock edge after it is first held in the register, whether it was applied or ignored, unless a new write from thread 0 lands on that same edge. A new write from thread 0 takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_tid | input | 3 | Thread issuing the write |
| wr_data | input | 3 | Write data: bit0 guard, bit1 split-to-2, bit2 split-to-4 |
| nap | input | 8 | Nap indication, one bit per thread |
| ctrl_rd | output | 3 | Control register readback |
| mode_two | output | 1 | Core is in 2-way split mode |
| mode_four | output | 1 | Core is in 4-way split mode |
| subcore_idx | output | 16 | Subcore number for each thread, 2 bits each |

## Verification
The hardest condition to reach from the ports is a split core that receives a conflicting request. This covers a 4-way request arriving while the core is in 2-way mode, and the reverse, and it includes the case where the guard bit is still set, so no merge can intervene. A split state only lasts while the guard stays set, or while some thread 1 to 7 stays awake. For that reason the random stimulus mostly writes from thread 0 with the guard set, and keeps the nap pattern incomplete most of the time. Directed sequences then build each split and issue the crossing request on purpose.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    PART_ONE  = 2'd0,
    PART_TWO  = 2'd1,
    PART_FOUR = 2'd2
  } part_mode_e;

  localparam int CTRL_W    = 3;
  localparam int BIT_GUARD = 0;
  localparam int BIT_REQ2  = 1;
  localparam int BIT_REQ4  = 2;
endpackage

// File: rtl/cpc_ctrl_reg.sv
module cpc_ctrl_reg #(
  parameter int TID_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [TID_W-1:0]          wr_tid,
  input  logic [cpc_pkg::CTRL_W-1:0] wr_data,
  input  logic                      consume,
  output logic [cpc_pkg::CTRL_W-1:0] ctrl_q
);
  import cpc_pkg::*;

  logic accept;
  assign accept = wr_en && (wr_tid == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (accept) begin
      ctrl_q <= wr_data;
    end else if (consume) begin
      ctrl_q[BIT_REQ2] <= 1'b0;
      ctrl_q[BIT_REQ4] <= 1'b0;
    end
  end
endmodule

// File: rtl/cpc_mode_fsm.sv
module cpc_mode_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                guard,
  input  logic                req_two,
  input  logic                req_four,
  input  logic                others_napping,
  output cpc_pkg::part_mode_e mode_q,
  output logic                consume
);
  import cpc_pkg::*;

  part_mode_e mode_d;
  logic       is_split;
  logic       merge_ok;
  logic       split_ok;

  assign is_split = (mode_q != PART_ONE);
  assign merge_ok = is_split && !guard && others_napping;
  assign split_ok = !is_split && guard && (req_two ^ req_four);
  assign consume  = req_two || req_four;

  always_comb begin
    mode_d = mode_q;
    if (merge_ok) begin
      mode_d = PART_ONE;
    end else if (split_ok) begin
      mode_d = req_two ? PART_TWO : PART_FOUR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= PART_ONE;
    end else begin
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/cpc_thread_map.sv
module cpc_thread_map #(
  parameter int THREADS = 8,
  parameter int SC_W    = 2
) (
  input  cpc_pkg::part_mode_e       mode,
  output logic [THREADS*SC_W-1:0]   idx
);
  import cpc_pkg::*;

  localparam int HALF    = THREADS / 2;
  localparam int QUARTER = THREADS / 4;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    localparam logic [SC_W-1:0] IDX_TWO  = SC_W'(t / HALF);
    localparam logic [SC_W-1:0] IDX_FOUR = SC_W'(t / QUARTER);
    always_comb begin
      case (mode)
        PART_TWO:  idx[t*SC_W +: SC_W] = IDX_TWO;
        PART_FOUR: idx[t*SC_W +: SC_W] = IDX_FOUR;
        default:   idx[t*SC_W +: SC_W] = '0;
      endcase
    end
  end
endmodule

// File: rtl/core_partition_ctrl.sv
module core_partition_ctrl #(
  parameter int THREADS = 8,
  parameter int SC_W    = 2,
  localparam int TID_W  = $clog2(THREADS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [TID_W-1:0]          wr_tid,
  input  logic [2:0]                wr_data,
  input  logic [THREADS-1:0]        nap,
  output logic [2:0]                ctrl_rd,
  output logic                      mode_two,
  output logic                      mode_four,
  output logic [THREADS*SC_W-1:0]   subcore_idx
);
  import cpc_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic              consume;
  logic              others_napping;
  part_mode_e        mode_q;

  assign others_napping = &nap[THREADS-1:1];

  cpc_ctrl_reg #(.TID_W(TID_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_tid  (wr_tid),
    .wr_data (wr_data),
    .consume (consume),
    .ctrl_q  (ctrl_q)
  );

  cpc_mode_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .guard          (ctrl_q[BIT_GUARD]),
    .req_two        (ctrl_q[BIT_REQ2]),
    .req_four       (ctrl_q[BIT_REQ4]),
    .others_napping (others_napping),
    .mode_q         (mode_q),
    .consume        (consume)
  );

  cpc_thread_map #(.THREADS(THREADS), .SC_W(SC_W)) u_map (
    .mode (mode_q),
    .idx  (subcore_idx)
  );

  assign ctrl_rd   = ctrl_q;
  assign mode_two  = (mode_q == PART_TWO);
  assign mode_four = (mode_q == PART_FOUR);
endmodule

// File: rtl/core_partition_ctrl_chk.sv
module core_partition_ctrl_chk #(
  parameter int THREADS = 8,
  parameter int SC_W    = 2,
  parameter int TID_W   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [TID_W-1:0]        wr_tid,
  input logic [THREADS-1:0]      nap,
  input logic [2:0]              ctrl_rd,
  input logic                    mode_two,
  input logic                    mode_four,
  input logic [THREADS*SC_W-1:0] subcore_idx
);
  logic split_now;
  assign split_now = mode_two || mode_four;

  p_whole_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !split_now |-> (subcore_idx == '0));

  p_split_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd == 3'b011 && !split_now) |=> mode_two);

  p_split_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd == 3'b101 && !split_now) |=> mode_four);

  p_status_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_two, mode_four}));

  p_auto_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[0] && (&nap[THREADS-1:1])) |=> !split_now);

  p_guard_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[0] && split_now) |=> split_now);

  p_no_two_to_four_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_two |=> !mode_four);

  p_no_four_to_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_four |=> !mode_two);

  p_foreign_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tid != '0 && ctrl_rd[2:1] == 2'b00) |=> $stable(ctrl_rd));
endmodule

bind core_partition_ctrl core_partition_ctrl_chk #(
  .THREADS (THREADS),
  .SC_W    (SC_W),
  .TID_W   (TID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_tid      (wr_tid),
  .nap         (nap),
  .ctrl_rd     (ctrl_rd),
  .mode_two    (mode_two),
  .mode_four   (mode_four),
  .subcore_idx (subcore_idx)
);

// File: tb/core_partition_ctrl_test.sv
module core_partition_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_tid = '0;
  logic [2:0]  wr_data = '0;
  logic [7:0]  nap = '0;
  logic [2:0]  ctrl_rd;
  logic        mode_two;
  logic        mode_four;
  logic [15:0] subcore_idx;

  int checks = 0;
  int errors = 0;
  int m_mode = 1;        // 1, 2 or 4 subcores
  logic [2:0] m_ctrl = '0;

  always #2.5 clk = ~clk;

  core_partition_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tid(wr_tid),
    .wr_data(wr_data), .nap(nap), .ctrl_rd(ctrl_rd),
    .mode_two(mode_two), .mode_four(mode_four), .subcore_idx(subcore_idx)
  );

  function automatic logic [15:0] exp_idx(int md);
    logic [15:0] v = '0;
    for (int t = 0; t < 8; t++) begin
      if (md == 2) v[2*t +: 2] = 2'(t / 4);
      else if (md == 4) v[2*t +: 2] = 2'(t / 2);
    end
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: drive, predict, clock, compare.
  task automatic step(logic we, logic [2:0] tid, logic [2:0] d, logic [7:0] nv, string tag);
    int nm;
    logic [2:0] nc;
    wr_en = we; wr_tid = tid; wr_data = d; nap = nv;
    nm = m_mode; nc = m_ctrl;
    if (m_mode != 1 && !m_ctrl[0] && (&nv[7:1])) nm = 1;
    else if (m_mode == 1 && m_ctrl[0] && (m_ctrl[1] ^ m_ctrl[2]))
      nm = m_ctrl[1] ? 2 : 4;
    if (m_ctrl[2:1] != 2'b00) nc[2:1] = 2'b00;
    if (we && tid == 3'd0) nc = d;
    @(posedge clk);
    #1;
    m_mode = nm; m_ctrl = nc;
    chk(tag, "mode_two", 16'(mode_two), 16'(m_mode == 2));
    chk(tag, "mode_four", 16'(mode_four), 16'(m_mode == 4));
    chk(tag, "ctrl_rd", 16'(ctrl_rd), 16'(m_ctrl));
    chk("R2", "subcore_idx", subcore_idx, exp_idx(m_mode));
    @(negedge clk);
  endtask

  task automatic idle(string tag, logic [7:0] nv);
    step(1'b0, 3'd0, 3'd0, nv, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "reset mode_two", 16'(mode_two), 16'd0);
    chk("R1", "reset mode_four", 16'(mode_four), 16'd0);
    chk("R1", "reset ctrl", 16'(ctrl_rd), 16'd0);
    chk("R1", "reset idx", subcore_idx, 16'd0);

    // R3: split to 2, request clears, then crossing request ignored (R7)
    step(1'b1, 3'd0, 3'b011, 8'h00, "R3");
    idle("R3", 8'h00);
    idle("R11", 8'h00);
    step(1'b1, 3'd0, 3'b101, 8'h00, "R7");
    idle("R7", 8'h00);
    idle("R7", 8'h00);
    // R6: guard set, all others nap, stay split
    idle("R6", 8'hFE);
    idle("R6", 8'hFF);
    // R5: clear guard, nap[0] awake still merges
    step(1'b1, 3'd0, 3'b000, 8'h01, "R5");
    idle("R5", 8'hFE);
    idle("R5", 8'h00);
    // R3 split to 4, then crossing request ignored (R7)
    step(1'b1, 3'd0, 3'b101, 8'h00, "R3");
    idle("R3", 8'h00);
    step(1'b1, 3'd0, 3'b011, 8'h00, "R7");
    idle("R7", 8'h00);
    // R5: merge needs all of 7:1, one awake blocks it
    step(1'b1, 3'd0, 3'b000, 8'h7E, "R5");
    idle("R5", 8'h7E);
    idle("R5", 8'hFE);
    // R8: both requests
    step(1'b1, 3'd0, 3'b111, 8'h00, "R8");
    idle("R8", 8'h00);
    idle("R8", 8'h00);
    // R9: request without guard
    step(1'b1, 3'd0, 3'b010, 8'h00, "R9");
    idle("R9", 8'h00);
    step(1'b1, 3'd0, 3'b100, 8'h00, "R9");
    idle("R9", 8'h00);
    // R10: foreign writes dropped
    step(1'b1, 3'd5, 3'b011, 8'h00, "R10");
    idle("R10", 8'h00);
    step(1'b1, 3'd1, 3'b101, 8'h00, "R10");
    idle("R10", 8'h00);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic        we;
      logic [2:0]  tid;
      logic [2:0]  d;
      logic [7:0]  nv;
      we  = ($urandom % 4) == 0;
      tid = (($urandom % 5) == 0) ? 3'($urandom) : 3'd0;
      d   = 3'($urandom);
      if (($urandom % 3) != 0) d[0] = 1'b1;
      nv  = (($urandom % 6) == 0) ? (8'hFE | 8'($urandom % 2)) : 8'($urandom);
      step(we, tid, d, nv, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule